// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Unit

This unit holds the control, status and interrupt logic of a battery-backed real-time clock. A 32.768 kHz base tick drives a 15-bit prescaler. Software picks an operating divider and a 4-bit rate code, and from these the unit raises a periodic flag and drives a square-wave output. The calendar chain is not part of this unit. It reports alarm matches and completed updates as one-cycle strobes, and each strobe sets its own flag. The three flags combine with per-source enables into one interrupt request.

Software uses a two-step access. A write to the index port chooses a register, and the data port then reads or writes that register. The status register holds the flags. It is read-only, and reading it clears it. If an event arrives in the same cycle as that read, the event is not lost: its flag sets one cycle later.

Top module: `rtc_pi_unit`

## Requirements
- R1: A write with `bus_addr`=0 loads the 7-bit index, and a read with `bus_addr`=0 returns {0, index}. A data access (`bus_addr`=1) goes to the indexed register: 0x0A control, 0x0B enables, 0x0C status, 0x0D power. Any other index reads 0x00, and writes to it are ignored.
- R2: Control register bit 7 reads the `upd_busy` input. Bits 6..0 read back as written. Bits 6..4 form the divider field and bits 3..0 the rate code. All bits reset to 0.
- R3: The prescaler advances once per `base_tick` only when the divider field is 010. Codes 110 and 111 hold the prescaler at zero. Every other code freezes it.
- R4: Rate code 0000 never sets the periodic flag and keeps `sqw_out` low.
- R5: Rate codes 3..15 give a period of 2^(code-1) base ticks. Codes 1 and 2 give 64 and 128 ticks. The periodic flag sets on the last tick of each period, counted from a prescaler value of zero.
- R6: When enable bit 3 is set, the rate code is nonzero and the divider is 010, `sqw_out` is low for the first half of each period and high for the second half. Otherwise `sqw_out` is low.
- R7: Status bit 6 (periodic), bit 5 (alarm) and bit 4 (update) each set on their event, whatever the enables hold. Status bits 3..0 read 0.
- R8: Status bit 7 and `irq` are 1 exactly when a flag is set together with its enable: bit 6 for periodic, bit 5 for alarm, bit 4 for update.
- R9: A read of the status register returns the flags as they were before the read, then clears all of them.
- R10: An event that arrives in the same cycle as a status read sets its flag one cycle after the read, unless another status read follows at once.
- R11: The power register reads {`pwr_ok`, 0000000}. Writes to the status and power registers change nothing.
- R12: The enable register reads back all 8 written bits, and `cal_halt` follows its bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs | input | 1 | Access strobe |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while a read is presented |
| base_tick | input | 1 | One-cycle strobe at the 32.768 kHz base rate |
| alarm_hit | input | 1 | Alarm match strobe from the calendar chain |
| update_done | input | 1 | Update-finished strobe from the calendar chain |
| upd_busy | input | 1 | Calendar update in progress |
| pwr_ok | input | 1 | Backup power valid |
| irq | output | 1 | Combined interrupt request |
| sqw_out | output | 1 | Square-wave output |
| cal_halt | output | 1 | Halt request to the calendar chain |

## Verification
Every rate code is run against a continuous tick stream, and the `irq` edges are compared cycle by cycle with a reference. This separates the power-of-two periods from each other, shows that the two aliased low codes land on 64 and 128, and shows that code zero stays silent. Divider codes are switched between hold, freeze and run in the middle of a count, which tells reset-to-zero apart from pause. Alarm and update strobes are applied with their enables off and on, and also in the same cycle as status reads and just before back-to-back reads. This tells flag-set apart from request-gating, and shows whether a coincident event is carried over or lost.

// File: rtl/rtc_pi_pkg.sv
// Shared constants for the RTC periodic interrupt unit.
// Assumes an 8-bit register file reached through a 7-bit index.
package rtc_pi_pkg;
    localparam int IDX_W_DEF  = 7;
    localparam int DATA_W_DEF = 8;
    localparam int N_SRC_DEF  = 3;
    localparam int CNT_W_DEF  = 15;

    // register indices
    localparam int IDX_CTRL   = 10;
    localparam int IDX_ENA    = 11;
    localparam int IDX_STAT   = 12;
    localparam int IDX_PWR    = 13;

    // divider field codes
    localparam logic [2:0] DIV_RUN = 3'b010;

    // flag positions inside the source vector (msb = periodic)
    localparam int SRC_UPD = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_PER = 2;
endpackage

// File: rtl/rtc_pi_regs.sv
// Index/data register access for the RTC unit.
// Holds the index, control and enable registers, and muxes read data.
// Assumes one access per cycle; flags and IRQ come from other blocks.
module rtc_pi_regs
    import rtc_pi_pkg::*;
#(
    parameter int IDX_W  = IDX_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int N_SRC  = N_SRC_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              upd_busy,
    input  logic              pwr_ok,
    input  logic [N_SRC-1:0]  flags,
    input  logic              irq_flag,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-2:0] reg_ctrl,
    output logic [DATA_W-1:0] reg_ena,
    output logic              stat_rd
);
    localparam int PAD_W = DATA_W - 1 - N_SRC;

    logic [IDX_W-1:0] idx_q;
    logic             data_wr;
    logic             data_rd;

    assign data_wr = bus_cs && bus_we && bus_addr;
    assign data_rd = bus_cs && !bus_we && bus_addr;
    assign stat_rd = data_rd && (idx_q == IDX_W'(IDX_STAT));

    // Purpose: capture the register index from the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (bus_cs && bus_we && !bus_addr)
            idx_q <= bus_wdata[IDX_W-1:0];
    end

    // Purpose: hold the writable control and enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_ctrl <= '0;
            reg_ena  <= '0;
        end else if (data_wr) begin
            if (idx_q == IDX_W'(IDX_CTRL))
                reg_ctrl <= bus_wdata[DATA_W-2:0];
            if (idx_q == IDX_W'(IDX_ENA))
                reg_ena <= bus_wdata;
        end
    end

    // Purpose: select read data for the index or data port.
    always_comb begin
        bus_rdata = '0;
        if (bus_cs && !bus_we) begin
            if (!bus_addr)
                bus_rdata = DATA_W'(idx_q);
            else if (idx_q == IDX_W'(IDX_CTRL))
                bus_rdata = {upd_busy, reg_ctrl};
            else if (idx_q == IDX_W'(IDX_ENA))
                bus_rdata = reg_ena;
            else if (idx_q == IDX_W'(IDX_STAT))
                bus_rdata = {irq_flag, flags, {PAD_W{1'b0}}};
            else if (idx_q == IDX_W'(IDX_PWR))
                bus_rdata = {pwr_ok, {(DATA_W-1){1'b0}}};
        end
    end

    // R12: enable register only changes on a data write aimed at it
    assert_ena_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && idx_q == IDX_W'(IDX_ENA)) |=> $stable(reg_ena));
    // R11: a status read never alters the control register
    assert_ctrl_stat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> $stable(reg_ctrl));
endmodule

// File: rtl/rtc_pi_rate.sv
// Prescaler, periodic event and square wave for the RTC unit.
// Assumes base_tick is a one-cycle strobe at the 32.768 kHz base rate.
// Period is 2^(rate-1) ticks; rates 1 and 2 alias to 64 and 128 ticks.
module rtc_pi_rate
    import rtc_pi_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic [2:0] div_sel,
    input  logic [3:0] rate_sel,
    input  logic       sqw_en,
    output logic       per_ev,
    output logic       sqw
);
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       expo;
    logic [CNT_W-1:0] mask;
    logic             running;
    logic             held;

    assign running = (div_sel == DIV_RUN);
    assign held    = (div_sel[2:1] == 2'b11);

    // Purpose: map the rate code to a period exponent.
    always_comb begin
        case (rate_sel)
            4'd1:    expo = 4'd6;
            4'd2:    expo = 4'd7;
            default: expo = rate_sel - 4'd1;
        endcase
        mask = ~({CNT_W{1'b1}} << expo);
    end

    // Purpose: advance, freeze or clear the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n || held)
            cnt_q <= '0;
        else if (running && base_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: flag the last tick of each period and form the square wave.
    always_comb begin
        per_ev = running && base_tick && (rate_sel != 4'd0)
                 && ((cnt_q & mask) == mask);
        sqw    = sqw_en && running && (rate_sel != 4'd0)
                 && cnt_q[4'(expo - 4'd1)];
    end

    // R3: hold codes force the prescaler to zero
    assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (cnt_q == '0));
    // R3: frozen codes keep the count
    assert_div_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !held) |=> $stable(cnt_q));
    // R4: rate code zero never produces a periodic event
    assert_rate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == 4'd0) |-> !per_ev);
endmodule

// File: rtl/rtc_pi_flags.sv
// Event flags with clear-on-read for the RTC unit.
// Each source sets its flag; a status read clears all flags and parks
// any coincident event so it sets its flag in the following cycle.
module rtc_pi_flags
    import rtc_pi_pkg::*;
#(
    parameter int N_SRC = N_SRC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev,
    input  logic             rd_clr,
    output logic [N_SRC-1:0] flg
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic f_q;
        logic p_q;

        // Purpose: set, clear-on-read and carry-over for one source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= 1'b0;
                p_q <= 1'b0;
            end else if (rd_clr) begin
                f_q <= 1'b0;
                p_q <= ev[i] | p_q;
            end else begin
                f_q <= f_q | ev[i] | p_q;
                p_q <= 1'b0;
            end
        end

        assign flg[i] = f_q;

        // R7: an event outside a status read sets the flag
        assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ev[i] && !rd_clr) |=> flg[i]);
        // R9: a status read leaves the flag clear
        assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_clr |=> !flg[i]);
        // R10: an event met during a read shows up once reads stop
        assert_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_clr && $past(rd_clr && ev[i])) |=> flg[i]);
    end
endmodule

// File: rtl/rtc_pi_unit.sv
// Top of the RTC periodic interrupt unit.
// Wires register access, prescaler and flags; forms the combined request.
// Assumes the calendar chain supplies one-cycle alarm and update strobes.
module rtc_pi_unit
    import rtc_pi_pkg::*;
#(
    parameter int IDX_W  = IDX_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int N_SRC  = N_SRC_DEF,
    parameter int CNT_W  = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs,
    input  logic              bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              base_tick,
    input  logic              alarm_hit,
    input  logic              update_done,
    input  logic              upd_busy,
    input  logic              pwr_ok,
    output logic              irq,
    output logic              sqw_out,
    output logic              cal_halt
);
    logic [DATA_W-2:0] reg_ctrl;
    logic [DATA_W-1:0] reg_ena;
    logic              stat_rd;
    logic              per_ev;
    logic [N_SRC-1:0]  ev;
    logic [N_SRC-1:0]  flg;
    logic [N_SRC-1:0]  ena;

    rtc_pi_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .upd_busy(upd_busy),
        .pwr_ok(pwr_ok), .flags(flg), .irq_flag(irq),
        .bus_rdata(bus_rdata), .reg_ctrl(reg_ctrl), .reg_ena(reg_ena),
        .stat_rd(stat_rd)
    );

    rtc_pi_rate #(.CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .div_sel(reg_ctrl[6:4]), .rate_sel(reg_ctrl[3:0]),
        .sqw_en(reg_ena[3]), .per_ev(per_ev), .sqw(sqw_out)
    );

    // Purpose: order the event strobes as periodic, alarm, update.
    always_comb begin
        ev          = '0;
        ev[SRC_PER] = per_ev;
        ev[SRC_ALM] = alarm_hit;
        ev[SRC_UPD] = update_done;
    end

    rtc_pi_flags #(.N_SRC(N_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev), .rd_clr(stat_rd), .flg(flg)
    );

    // Purpose: gate flags with their enables into one request.
    assign ena      = reg_ena[6:4];
    assign irq      = |(flg & ena);
    assign cal_halt = reg_ena[7];

    // R8: a request always has a flag behind it
    assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flg != '0));
    // R9: the request drops after a status read with no pending events
    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ev == '0) |=> !irq);
endmodule

// File: tb/rtc_pi_unit_test.sv
module rtc_pi_unit_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, cs, addr, we, tick, alm, upd, busy, pwr;
    logic [7:0] wd, rdata;
    logic irq, sqw, halt;

    rtc_pi_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wd), .bus_rdata(rdata), .base_tick(tick), .alarm_hit(alm),
        .update_done(upd), .upd_busy(busy), .pwr_ok(pwr), .irq(irq),
        .sqw_out(sqw), .cal_halt(halt)
    );

    integer vectors = 0, errs = 0;

    // reference state
    logic [6:0] m_a, m_idx;
    logic [7:0] m_b;
    logic [2:0] m_f, m_p;
    integer     m_cnt;

    function automatic integer m_period(input logic [3:0] r);
        if (r == 4'd1) return 64;
        if (r == 4'd2) return 128;
        if (r == 4'd0) return 1;
        return 1 << (r - 1);
    endfunction

    function automatic logic [7:0] m_rd(input logic a);
        if (!a) return {1'b0, m_idx};
        case (m_idx)
            7'h0A: return {busy, m_a};
            7'h0B: return m_b;
            7'h0C: return {|(m_f & m_b[6:4]), m_f, 4'b0};
            7'h0D: return {pwr, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic c, input logic a, input logic w, input logic [7:0] d,
                        input logic t, input logic al, input logic up, input string tag = "");
        integer per;
        logic pev, rdc, e_sqw;
        logic [2:0] ev;
        @(negedge clk);
        cs = c; addr = a; we = w; wd = d; tick = t; alm = al; upd = up;
        #1;
        per   = m_period(m_a[3:0]);
        e_sqw = m_b[3] && m_a[3:0] != 0 && m_a[6:4] == 3'b010 && (m_cnt % per) >= per / 2;
        chk("R8 irq", {7'b0, irq}, {7'b0, |(m_f & m_b[6:4])});
        chk("R6 sqw", {7'b0, sqw}, {7'b0, e_sqw});
        chk("R12 cal_halt", {7'b0, halt}, {7'b0, m_b[7]});
        if (c && !w) chk(tag, rdata, m_rd(a));
        @(posedge clk);
        pev = m_a[6:4] == 3'b010 && t && m_a[3:0] != 0 && (m_cnt % per == per - 1);
        ev  = {pev, al, up};
        rdc = c && a && !w && m_idx == 7'h0C;
        for (int i = 0; i < 3; i++) begin
            if (rdc) begin
                m_p[i] = ev[i] | m_p[i];
                m_f[i] = 1'b0;
            end else begin
                m_f[i] = m_f[i] | ev[i] | m_p[i];
                m_p[i] = 1'b0;
            end
        end
        if (m_a[6:5] == 2'b11) m_cnt = 0;
        else if (m_a[6:4] == 3'b010 && t) m_cnt = (m_cnt + 1) % 32768;
        if (c && w && !a) m_idx = d[6:0];
        if (c && w && a) begin
            if (m_idx == 7'h0A) m_a = d[6:0];
            if (m_idx == 7'h0B) m_b = d;
        end
    endtask

    task automatic wri(input logic [7:0] i);  step(1, 0, 1, i, 0, 0, 0); endtask
    task automatic wrd(input logic [7:0] v);  step(1, 1, 1, v, 0, 0, 0); endtask
    task automatic rdd(input string tag);     step(1, 1, 0, 8'h00, 0, 0, 0, tag); endtask
    task automatic wreg(input logic [7:0] i, input logic [7:0] v); wri(i); wrd(v); endtask
    task automatic run(input integer n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 8'h00, 1, 0, 0);
    endtask
    task automatic clr_stat; wri(8'h0C); rdd("R9 clear"); endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    initial begin
        #4_000_000;
        errs++;
        $display("FAIL watchdog all-R act=hung exp=done");
        finish_run();
    end

    initial begin
        rst_n = 0; cs = 0; addr = 0; we = 0; wd = 0; tick = 0; alm = 0; upd = 0;
        busy = 0; pwr = 1;
        m_a = 0; m_idx = 0; m_b = 0; m_f = 0; m_p = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // reset state
        wri(8'h0A); rdd("R2 reset ctrl");
        wri(8'h0C); rdd("R7 reset status");
        // R1 index port readback and unmapped index
        step(1, 0, 0, 8'h00, 0, 0, 0, "R1 index read");
        wreg(8'h20, 8'h5A); rdd("R1 unmapped");
        step(1, 0, 0, 8'h00, 0, 0, 0, "R1 index read 0x20");
        // R2 control readback and busy bit
        wreg(8'h0A, 8'h55); rdd("R2 ctrl rb");
        busy = 1; rdd("R2 busy bit"); busy = 0;
        // R12 enable register and halt
        wreg(8'h0B, 8'h80); rdd("R12 ena rb");
        wrd(8'h00);
        // R11 power register and ignored writes
        wri(8'h0D); rdd("R11 pwr on"); pwr = 0; rdd("R11 pwr off"); pwr = 1;
        wrd(8'hFF); rdd("R11 pwr write ignored");
        wreg(8'h0C, 8'hFF); rdd("R11 stat write ignored");

        // R5 periodic: rate 6 = 32 ticks, PIE on
        wreg(8'h0A, 8'h66);           // hold prescaler at zero
        wreg(8'h0B, 8'h40);
        wreg(8'h0A, 8'h26);
        run(31); clr_stat(); rdd("R5 before period");
        run(1); rdd("R5 period 32");
        run(70); rdd("R5 after two periods");
        // every rate code, including aliases
        for (int r = 1; r < 16; r++) begin
            wreg(8'h0A, 8'h60 | r[7:0]);
            wreg(8'h0A, 8'h20 | r[7:0]);
            clr_stat();
            run(m_period(r[3:0]) + 2);
            rdd("R5 rate sweep");
        end
        // R4 rate zero
        wreg(8'h0A, 8'h20); clr_stat(); run(300); rdd("R4 rate zero");
        // R3 freeze with code 000 mid-count, then resume
        wreg(8'h0A, 8'h63); wreg(8'h0A, 8'h23); run(2);
        wreg(8'h0A, 8'h03); run(20); clr_stat(); rdd("R3 frozen");
        wreg(8'h0A, 8'h23); clr_stat(); run(3); rdd("R3 resumed");
        // R3 hold code 111
        wreg(8'h0A, 8'h73); run(10); wreg(8'h0A, 8'h23); clr_stat(); run(3); rdd("R3 held");
        run(1); rdd("R3 held release");

        // R7 alarm/update flags without enables, then R8 gating
        wreg(8'h0A, 8'h20); wreg(8'h0B, 8'h00);
        wri(8'h0C); rdd("R9 clean");
        step(0, 0, 0, 8'h00, 0, 1, 0); step(0, 0, 0, 8'h00, 0, 0, 1);
        wri(8'h0B); wrd(8'h20); wri(8'h0C); rdd("R8 alarm gated on");
        rdd("R9 cleared after read");
        wri(8'h0B); wrd(8'h10);
        step(0, 0, 0, 8'h00, 0, 0, 1); wri(8'h0C); rdd("R8 update request");
        // R10 coincident event with a status read
        wri(8'h0B); wrd(8'h30); wri(8'h0C);
        step(1, 1, 0, 8'h00, 0, 1, 0, "R10 read with alarm");
        rdd("R10 carried alarm");
        // R10 back-to-back reads keep the parked event
        step(1, 1, 0, 8'h00, 0, 0, 1, "R10 read with update");
        rdd("R10 second read");
        step(0, 0, 0, 8'h00, 0, 0, 0);
        rdd("R10 parked update");

        // R6 square wave at rate 3 and rate 7
        wri(8'h0B); wrd(8'h08);
        wreg(8'h0A, 8'h63); wreg(8'h0A, 8'h23); run(40);
        wreg(8'h0A, 8'h27); run(200);
        wreg(8'h0A, 8'h20); run(10);
        wreg(8'h0A, 8'h63); run(5);

        finish_run();
    end
endmodule